// File: doc/BRIEF.md
# Coherent Transfer Address Blocker

This block sequences coherence traffic for a caching agent that sits between inner masters and an outer slave. It keeps a small table of transfers that are still open, each recorded by kind (acquire, probe or release) and by cache block address. For one presented address it tells the agent, every cycle, which kinds of new transfer may start on that block and which must wait.

The blocking is asymmetric and ordered by priority. A release ranks above a probe, and a probe ranks above an acquire. An open acquire or probe holds back new acquires and probes to the same block, but a nested release still gets through. An open release holds back all three kinds. Each table slot is freed only by the acknowledgement that closes its own kind. A start event that arrives while its kind is stalled is dropped and not recorded. Blocks at different addresses never affect each other, except that a full table stalls every new start.

Top module: `coh_xfer_blocker`

## Requirements
- R1: After reset the table is empty, and all three stall outputs are low for every address.
- R2: While an acquire is open on a block, `stall_acq` and `stall_prb` are high for that block and `stall_rel` stays low.
- R3: While a probe is open on a block, `stall_acq` and `stall_prb` are high for that block and `stall_rel` stays low.
- R4: While a release is open on a block, `stall_acq`, `stall_prb` and `stall_rel` are all high for that block.
- R5: Addresses are compared as blocks of `BLOCK_BYTES` bytes. The low log2(`BLOCK_BYTES`) address bits play no part in a match.
- R6: A transfer that is open on one block raises no stall for a different block, as long as the table is not full.
- R7: A completion event clears only an open entry whose kind and block both match. The encoding is 0 = grant acknowledge closing an acquire, 1 = probe acknowledge closing a probe, 2 = release acknowledge closing a release. A completion whose kind does not match leaves the stalls unchanged.
- R8: A start event on `req_addr` is recorded only if the stall for its kind (0 acquire, 1 probe, 2 release) is low in that cycle. Otherwise it is dropped and has no later effect.
- R9: When all `ENTRIES` slots are in use, all three stall outputs are high for every address.
- R10: A start and a completion in the same cycle both take effect on that clock edge. The stalls reflect the new table from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_addr | input | ADDR_W | Address that is queried, and the address of a start event |
| start_valid | input | 1 | A transfer of kind `start_kind` is starting on `req_addr` |
| start_kind | input | 2 | 0 acquire, 1 probe, 2 release, 3 ignored |
| done_valid | input | 1 | A completion acknowledgement is arriving |
| done_kind | input | 2 | Kind of transfer being closed (same encoding) |
| done_addr | input | ADDR_W | Block address of the transfer being closed |
| stall_acq | output | 1 | A new acquire on `req_addr` must wait |
| stall_prb | output | 1 | A new probe on `req_addr` must wait |
| stall_rel | output | 1 | A new release on `req_addr` must wait |

## Verification
Each kind of open transfer is queried at its own block, at an unaligned address inside that block, and at a foreign block. Together these separate the per-kind rules from the block match and from address independence. A release nested under an acquire, followed by a probe acknowledgement of the wrong kind, shows that a slot is freed only by its own acknowledgement. A start that is stalled and then has its blocker removed shows that the dropped start left no entry behind. The table is filled to capacity, and a start and a completion are issued in the same cycle, to check the full-table stall and that two events in one cycle both take effect.

// File: rtl/coh_blk_pkg.sv
package coh_blk_pkg;
   typedef enum logic [1:0] {
      XFER_ACQ  = 2'd0,
      XFER_PRB  = 2'd1,
      XFER_REL  = 2'd2,
      XFER_NONE = 2'd3
   } xfer_kind_e;
endpackage

// File: rtl/coh_blk_slot.sv
module coh_blk_slot
   import coh_blk_pkg::*;
#(
   parameter int TAG_W = 26
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_i,
   input  xfer_kind_e       alloc_kind_i,
   input  logic [TAG_W-1:0] alloc_tag_i,
   input  logic             clr_valid_i,
   input  xfer_kind_e       clr_kind_i,
   input  logic [TAG_W-1:0] clr_tag_i,
   input  logic [TAG_W-1:0] look_tag_i,
   output logic             busy_o,
   output logic             clr_hit_o,
   output logic             look_acq_o,
   output logic             look_prb_o,
   output logic             look_rel_o
);
   logic             busy_q;
   xfer_kind_e       kind_q;
   logic [TAG_W-1:0] tag_q;
   logic             look_hit;

   assign clr_hit_o = busy_q && clr_valid_i && (clr_kind_i == kind_q) && (clr_tag_i == tag_q);
   assign look_hit  = busy_q && (look_tag_i == tag_q);
   assign look_acq_o = look_hit && (kind_q == XFER_ACQ);
   assign look_prb_o = look_hit && (kind_q == XFER_PRB);
   assign look_rel_o = look_hit && (kind_q == XFER_REL);
   assign busy_o     = busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         kind_q <= XFER_NONE;
         tag_q  <= '0;
      end else if (alloc_i) begin
         busy_q <= 1'b1;
         kind_q <= alloc_kind_i;
         tag_q  <= alloc_tag_i;
      end else if (clr_hit_o) begin
         busy_q <= 1'b0;
      end
   end

   // R8
   alloc_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_i |-> !busy_q);
   // R7
   clr_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_hit_o |=> !busy_q);
endmodule

// File: rtl/coh_blk_rules.sv
module coh_blk_rules #(
   parameter int N = 4
) (
   input  logic [N-1:0] busy_i,
   input  logic [N-1:0] hit_acq_i,
   input  logic [N-1:0] hit_prb_i,
   input  logic [N-1:0] hit_rel_i,
   output logic         full_o,
   output logic         stall_acq_o,
   output logic         stall_prb_o,
   output logic         stall_rel_o
);
   logic any_acq, any_prb, any_rel;

   assign any_acq = |hit_acq_i;
   assign any_prb = |hit_prb_i;
   assign any_rel = |hit_rel_i;
   assign full_o  = &busy_i;

   // Lowest priority kinds wait behind everything on the block.
   assign stall_acq_o = full_o | any_acq | any_prb | any_rel;
   assign stall_prb_o = full_o | any_acq | any_prb | any_rel;
   // Releases nest under acquires and probes; only another release blocks.
   assign stall_rel_o = full_o | any_rel;
endmodule

// File: rtl/coh_xfer_blocker.sv
module coh_xfer_blocker
   import coh_blk_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int BLOCK_BYTES = 64,
   parameter int ENTRIES     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              start_valid,
   input  logic [1:0]        start_kind,
   input  logic              done_valid,
   input  logic [1:0]        done_kind,
   input  logic [ADDR_W-1:0] done_addr,
   output logic              stall_acq,
   output logic              stall_prb,
   output logic              stall_rel
);
   localparam int OFFS_W = $clog2(BLOCK_BYTES);
   localparam int TAG_W  = ADDR_W - OFFS_W;

   initial begin
      blk_pow2_chk: assert ((1 << OFFS_W) == BLOCK_BYTES)
         else $error("BLOCK_BYTES must be a power of two");
      tag_width_chk: assert (TAG_W >= 1)
         else $error("ADDR_W must exceed the block offset width");
      entries_chk: assert (ENTRIES >= 1)
         else $error("ENTRIES must be at least one");
   end

   logic [TAG_W-1:0]   req_tag, done_tag;
   xfer_kind_e         s_kind, d_kind;
   logic [ENTRIES-1:0] busy_vec, clr_vec, alloc_vec;
   logic [ENTRIES-1:0] acq_vec, prb_vec, rel_vec;
   logic               full, kind_stall, start_ok;

   assign req_tag  = req_addr[ADDR_W-1:OFFS_W];
   assign done_tag = done_addr[ADDR_W-1:OFFS_W];
   assign s_kind   = xfer_kind_e'(start_kind);
   assign d_kind   = xfer_kind_e'(done_kind);

   always_comb begin
      case (s_kind)
         XFER_ACQ: kind_stall = stall_acq;
         XFER_PRB: kind_stall = stall_prb;
         XFER_REL: kind_stall = stall_rel;
         default:  kind_stall = 1'b1;
      endcase
   end
   assign start_ok = start_valid && !kind_stall;

   // Lowest free slot wins the allocation.
   always_comb begin
      logic taken;
      taken     = 1'b0;
      alloc_vec = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (!busy_vec[i] && !taken) begin
            alloc_vec[i] = start_ok;
            taken        = 1'b1;
         end
      end
   end

   for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      coh_blk_slot #(.TAG_W(TAG_W)) u_slot (
         .clk         (clk),
         .rst_n       (rst_n),
         .alloc_i     (alloc_vec[g]),
         .alloc_kind_i(s_kind),
         .alloc_tag_i (req_tag),
         .clr_valid_i (done_valid),
         .clr_kind_i  (d_kind),
         .clr_tag_i   (done_tag),
         .look_tag_i  (req_tag),
         .busy_o      (busy_vec[g]),
         .clr_hit_o   (clr_vec[g]),
         .look_acq_o  (acq_vec[g]),
         .look_prb_o  (prb_vec[g]),
         .look_rel_o  (rel_vec[g])
      );
   end

   coh_blk_rules #(.N(ENTRIES)) u_rules (
      .busy_i     (busy_vec),
      .hit_acq_i  (acq_vec),
      .hit_prb_i  (prb_vec),
      .hit_rel_i  (rel_vec),
      .full_o     (full),
      .stall_acq_o(stall_acq),
      .stall_prb_o(stall_prb),
      .stall_rel_o(stall_rel)
   );

   // R8
   one_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(alloc_vec));
   // R10
   grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_ok && !(|clr_vec)) |=> ($countones(busy_vec) == $past($countones(busy_vec)) + 1));
   // R10
   swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_ok && (|clr_vec)) |=> ($countones(busy_vec) == $past($countones(busy_vec))));
   // R9
   full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(busy_vec) == ENTRIES) |-> (stall_acq && stall_prb && stall_rel));
   // R1
   reset_empty_chk: assert property (@(posedge clk)
      $past(!rst_n) |-> (busy_vec == '0));
endmodule

// File: tb/coh_xfer_blocker_tb.sv
module coh_xfer_blocker_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] req_addr = '0;
   logic        start_valid = 1'b0;
   logic [1:0]  start_kind = '0;
   logic        done_valid = 1'b0;
   logic [1:0]  done_kind = '0;
   logic [31:0] done_addr = '0;
   logic        stall_acq, stall_prb, stall_rel;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   typedef struct {
      logic [2:0] stalls;
      string      tag;
   } exp_t;
   exp_t exp_q[$];

   always #5 clk = ~clk;

   coh_xfer_blocker u_dut (
      .clk(clk), .rst_n(rst_n), .req_addr(req_addr),
      .start_valid(start_valid), .start_kind(start_kind),
      .done_valid(done_valid), .done_kind(done_kind), .done_addr(done_addr),
      .stall_acq(stall_acq), .stall_prb(stall_prb), .stall_rel(stall_rel)
   );

   // Monitor: compares outputs against the scoreboard queue.
   initial begin
      forever begin
         @(negedge clk);
         #2;
         while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if ({stall_acq, stall_prb, stall_rel} !== e.stalls) begin
               fails++;
               $display("FAIL %s: stalls acq/prb/rel actual %b expected %b",
                        e.tag, {stall_acq, stall_prb, stall_rel}, e.stalls);
            end
         end
      end
   end

   task automatic expect_at(input logic [31:0] a, input logic [2:0] s, input string tag);
      exp_t e;
      @(negedge clk);
      req_addr = a;
      e.stalls = s;
      e.tag    = tag;
      exp_q.push_back(e);
   endtask

   task automatic start_x(input logic [1:0] k, input logic [31:0] a);
      @(negedge clk);
      req_addr = a; start_kind = k; start_valid = 1'b1;
      @(negedge clk);
      start_valid = 1'b0;
   endtask

   task automatic done_x(input logic [1:0] k, input logic [31:0] a);
      @(negedge clk);
      done_addr = a; done_kind = k; done_valid = 1'b1;
      @(negedge clk);
      done_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: empty after reset
      expect_at(32'h1000, 3'b000, "R1 reset blk A");
      expect_at(32'h9FC0, 3'b000, "R1 reset other blk");
      // R2: acquire open
      start_x(2'd0, 32'h1000);
      expect_at(32'h1000, 3'b110, "R2 acquire open");
      // R5: unaligned address in same block
      expect_at(32'h103F, 3'b110, "R5 offset bits ignored");
      expect_at(32'h1040, 3'b000, "R5 next block clear");
      // R6: other block unaffected
      expect_at(32'h2000, 3'b000, "R6 other block");
      // R4: nested release accepted under acquire
      start_x(2'd2, 32'h1010);
      expect_at(32'h1000, 3'b111, "R4 release nested");
      // R7: wrong-kind completion is ignored
      done_x(2'd1, 32'h1000);
      expect_at(32'h1000, 3'b111, "R7 probe ack ignored");
      done_x(2'd2, 32'h1020);
      expect_at(32'h1000, 3'b110, "R7 release ack clears release");
      done_x(2'd0, 32'h1000);
      expect_at(32'h1000, 3'b000, "R7 grant ack clears acquire");
      // R3: probe open
      start_x(2'd1, 32'h2000);
      expect_at(32'h2000, 3'b110, "R3 probe open");
      // R8: stalled acquire start is dropped
      start_x(2'd0, 32'h2000);
      done_x(2'd1, 32'h2000);
      expect_at(32'h2000, 3'b000, "R8 stalled start dropped");
      // R4: release alone
      start_x(2'd2, 32'h3000);
      expect_at(32'h3000, 3'b111, "R4 release open");
      expect_at(32'h3040, 3'b000, "R6 neighbour of release");
      done_x(2'd2, 32'h3000);
      expect_at(32'h3000, 3'b000, "R7 release done");
      // R9: fill the table
      start_x(2'd0, 32'h4000);
      start_x(2'd0, 32'h5000);
      start_x(2'd0, 32'h6000);
      start_x(2'd0, 32'h7000);
      expect_at(32'h8000, 3'b111, "R9 full table");
      start_x(2'd2, 32'h9000); // dropped: table full
      done_x(2'd0, 32'h5000);
      expect_at(32'h9000, 3'b000, "R8 start while full dropped");
      expect_at(32'h5000, 3'b000, "R9 slot freed");
      // R10: start and completion in one cycle
      @(negedge clk);
      req_addr = 32'h8000; start_kind = 2'd2; start_valid = 1'b1;
      done_addr = 32'h4000; done_kind = 2'd0; done_valid = 1'b1;
      @(negedge clk);
      start_valid = 1'b0; done_valid = 1'b0;
      expect_at(32'h8000, 3'b111, "R10 start same cycle");
      expect_at(32'h4000, 3'b000, "R10 done same cycle");
      expect_at(32'hA000, 3'b000, "R10 table not full");
      @(negedge clk);
      #3;
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule